// File: doc/BRIEF.md
# Offset Min-Sum Check Node Unit

This block performs the check-node update for a single lane of a layered decoder for quasi-cyclic low-density parity-check codes. During one layer it receives the variable-to-check log-likelihood messages of one prototype row, one per cycle, in two's complement. A flag marks the last message of the row. While the messages arrive, the unit keeps three things: a running parity of the sign bits, the smallest and second-smallest magnitudes, and the edge index where the smallest occurred. It also stores the sign bit of every edge.

When the row closes, the unit streams back one check-to-variable message per input edge, one per cycle and in arrival order. Each reply is extrinsic, so it never depends on the receiving edge's own input magnitude or sign. The reply magnitude is reduced by a programmable offset and floored at zero. This takes the place of the exact hyperbolic-tangent rule with a cheap approximation. The offset is captured together with the last input of the row. Inputs that arrive while replies are streaming out are not accepted.

Top module: `oms_check_node`

## Requirements
- R1: After reset, out_valid_o and out_last_o are low, and the unit is ready to collect a new row.
- R2: The reply sign for edge i equals the XOR of the sign bits (bit W-1) of all inputs of the row, XORed with the sign bit of edge i. A zero input counts as positive.
- R3: An input magnitude is its absolute value. The most negative code (-2^(W-1), 8'h80 by default) is saturated to magnitude 2^(W-1)-1 (127 by default).
- R4: The edge holding the smallest magnitude receives the second-smallest magnitude, and every other edge receives the smallest. On equal magnitudes, the earliest edge holds the smallest. For a one-edge row the second-smallest is 2^(W-1)-1.
- R5: The reply magnitude is max(0, m - offset), where m is the magnitude selected by R4. The offset is the value of offset_i sampled on the cycle the row closes, and later changes to offset_i do not affect that row.
- R6: Replies start on the cycle after the row closes and come one per cycle in input order. out_valid_o stays high for exactly as many cycles as the row had inputs, and out_last_o is high only on the final reply. The reply value is the two's-complement word -mag when the R2 sign is 1 and +mag otherwise.
- R7: in_valid_i, in_llr_i and in_last_i are ignored while replies are streaming. Such inputs change neither the current replies nor the following row.
- R8: A row closes when an input with in_last_i high is accepted, or automatically when its DMAX-th input is accepted.
- R9: All tracking state is cleared after the final reply, so consecutive rows are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input message valid |
| in_last_i | input | 1 | Input message is the last of the row |
| in_llr_i | input | W | Variable-to-check message, two's complement |
| offset_i | input | W-1 | Offset subtracted from reply magnitudes |
| out_valid_o | output | 1 | Reply message valid |
| out_last_o | output | 1 | Reply is the last of the row |
| out_msg_o | output | W | Check-to-variable reply, two's complement |

## Verification
The rows under test each isolate one effect:
- A mixed-sign row containing a zero checks that the sign parity is extrinsic and that zero counts as positive.
- A row with the most negative code next to a small value shows whether saturation is applied, because a wrong magnitude of zero would move the minimum.
- An offset larger than the smallest magnitude separates subtraction with a zero floor from wrap-around. Changing offset_i while replies stream shows whether the offset was captured.
- Tie rows, one-edge rows and full-length rows without a last flag exercise minimum selection and automatic closing.
- Back-to-back rows with noise driven during emission confirm that inputs are ignored and that state is cleared between rows.

// File: rtl/oms_pkg.sv
package oms_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EMIT    = 1'b1
  } cn_state_e;
endpackage

// File: rtl/oms_min_track.sv
module oms_min_track #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [W-1:0]  llr_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-2:0]  min1_o,
  output logic [W-2:0]  min2_o,
  output logic [IW-1:0] idx_o
);
  localparam int MW = W - 1;
  localparam logic [MW-1:0] MAX_MAG = {MW{1'b1}};
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {MW{1'b0}}};

  logic [MW-1:0] min1_q, min2_q, mag;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  neg;

  // absolute value, most negative code saturates
  always_comb begin
    neg = ~llr_i + W'(1);
    if (!llr_i[W-1])            mag = llr_i[MW-1:0];
    else if (llr_i == MOST_NEG) mag = MAX_MAG;
    else                        mag = neg[MW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min1_q <= MAX_MAG;
      min2_q <= MAX_MAG;
      idx_q  <= '0;
    end else if (clr_i) begin
      min1_q <= MAX_MAG;
      min2_q <= MAX_MAG;
      idx_q  <= '0;
    end else if (en_i) begin
      if (mag < min1_q) begin
        min2_q <= min1_q;
        min1_q <= mag;
        idx_q  <= idx_i;
      end else if (mag < min2_q) begin
        min2_q <= mag;
      end
    end
  end

  assign min1_o = min1_q;
  assign min2_o = min2_q;
  assign idx_o  = idx_q;

  p_min_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min1_q <= min2_q);
  p_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && llr_i == MOST_NEG && min1_q == MAX_MAG) |=> (min1_q == MAX_MAG || $changed(idx_q) == 1'b0));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (min1_q == MAX_MAG && min2_q == MAX_MAG));
endmodule

// File: rtl/oms_sign_store.sv
module oms_sign_store #(
  parameter int DMAX = 16,
  parameter int IW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          sgn_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          ext_sgn_o
);
  logic [DMAX-1:0] sgn_q;
  logic            tot_q;

  for (genvar g = 0; g < DMAX; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 sgn_q[g] <= 1'b0;
      else if (clr_i)                              sgn_q[g] <= 1'b0;
      else if (en_i && wr_idx_i == IW'(g))         sgn_q[g] <= sgn_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tot_q <= 1'b0;
    else if (clr_i)   tot_q <= 1'b0;
    else if (en_i)    tot_q <= tot_q ^ sgn_i;
  end

  // extrinsic sign: remove own contribution from parity
  assign ext_sgn_o = tot_q ^ sgn_q[rd_idx_i];

  p_sign_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tot_q == 1'b0 && sgn_q == '0));
  p_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (tot_q == ($past(tot_q) ^ $past(sgn_i))));
endmodule

// File: rtl/oms_out_gen.sv
module oms_out_gen #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic [W-2:0]  min1_i,
  input  logic [W-2:0]  min2_i,
  input  logic [IW-1:0] min_idx_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [W-2:0]  offset_i,
  input  logic          sgn_i,
  output logic [W-1:0]  msg_o
);
  localparam int MW = W - 1;
  logic [MW-1:0] sel, adj;
  logic [W-1:0]  pos;

  always_comb begin
    sel = (rd_idx_i == min_idx_i) ? min2_i : min1_i;
    adj = (sel > offset_i) ? (sel - offset_i) : '0;
    pos = {1'b0, adj};
    msg_o = sgn_i ? (~pos + W'(1)) : pos;
  end

  always_comb begin
    p_no_overflow_r5: assert (adj <= sel);
  end
endmodule

// File: rtl/oms_check_node.sv
module oms_check_node
  import oms_pkg::*;
#(
  parameter int W    = 8,
  parameter int DMAX = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic         in_last_i,
  input  logic [W-1:0] in_llr_i,
  input  logic [W-2:0] offset_i,
  output logic         out_valid_o,
  output logic         out_last_o,
  output logic [W-1:0] out_msg_o
);
  localparam int IW = (DMAX > 2) ? $clog2(DMAX) : 1;
  localparam int MW = W - 1;

  cn_state_e     state_q;
  logic [IW-1:0] cnt_q, rd_q, last_idx_q;
  logic [MW-1:0] off_q;
  logic          accept, close, emit_done, ext_sgn;
  logic [MW-1:0] min1, min2;
  logic [IW-1:0] min_idx;

  assign accept    = in_valid_i && (state_q == ST_COLLECT);
  assign close     = accept && (in_last_i || cnt_q == IW'(DMAX - 1));
  assign emit_done = (state_q == ST_EMIT) && (rd_q == last_idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_COLLECT;
      cnt_q      <= '0;
      rd_q       <= '0;
      last_idx_q <= '0;
      off_q      <= '0;
    end else begin
      case (state_q)
        ST_COLLECT: begin
          if (close) begin
            state_q    <= ST_EMIT;
            last_idx_q <= cnt_q;
            off_q      <= offset_i;
            cnt_q      <= '0;
            rd_q       <= '0;
          end else if (accept) begin
            cnt_q <= cnt_q + IW'(1);
          end
        end
        ST_EMIT: begin
          if (emit_done) begin
            state_q <= ST_COLLECT;
            rd_q    <= '0;
          end else begin
            rd_q <= rd_q + IW'(1);
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  oms_min_track #(.W(W), .IW(IW)) u_min (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (emit_done),
    .en_i   (accept),
    .llr_i  (in_llr_i),
    .idx_i  (cnt_q),
    .min1_o (min1),
    .min2_o (min2),
    .idx_o  (min_idx)
  );

  oms_sign_store #(.DMAX(DMAX), .IW(IW)) u_sgn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (emit_done),
    .en_i      (accept),
    .sgn_i     (in_llr_i[W-1]),
    .wr_idx_i  (cnt_q),
    .rd_idx_i  (rd_q),
    .ext_sgn_o (ext_sgn)
  );

  oms_out_gen #(.W(W), .IW(IW)) u_out (
    .min1_i    (min1),
    .min2_i    (min2),
    .min_idx_i (min_idx),
    .rd_idx_i  (rd_q),
    .offset_i  (off_q),
    .sgn_i     (ext_sgn),
    .msg_o     (out_msg_o)
  );

  assign out_valid_o = (state_q == ST_EMIT);
  assign out_last_o  = emit_done;

  p_reply_follows_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close |=> (out_valid_o && rd_q == '0));
  p_last_in_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  p_gap_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> !out_valid_o);
  p_ignore_in_emit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> $stable(cnt_q));
  p_offset_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> $stable(off_q));
  p_autoclose_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cnt_q == IW'(DMAX - 1)) |=> out_valid_o);
endmodule

// File: tb/oms_check_node_bench.sv
`timescale 1ns/1ps
module oms_check_node_bench;
  localparam int W = 8;
  localparam int DMAX = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [W-1:0] in_llr = '0;
  logic [W-2:0] offset = '0;
  logic out_valid, out_last;
  logic [W-1:0] out_msg;

  int total = 0, fails = 0;
  bit done = 1'b0;
  int vec[DMAX];

  always #4 clk = ~clk;

  oms_check_node #(.W(W), .DMAX(DMAX)) u_oms_check_node (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_last_i(in_last),
    .in_llr_i(in_llr), .offset_i(offset), .out_valid_o(out_valid),
    .out_last_o(out_last), .out_msg_o(out_msg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int magof(input int v);
    if (v == -128) return 127;
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [W-1:0] exp_msg(input int n, input int off, input int j);
    int m1 = 127, m2 = 127, mi = 0, m;
    bit tot = 1'b0;
    for (int k = 0; k < n; k++) begin
      tot ^= (vec[k] < 0);
      if (magof(vec[k]) < m1) begin m2 = m1; m1 = magof(vec[k]); mi = k; end
      else if (magof(vec[k]) < m2) m2 = magof(vec[k]);
    end
    m = (j == mi) ? m2 : m1;
    m = (m > off) ? m - off : 0;
    return (tot ^ (vec[j] < 0)) ? W'(-m) : W'(m);
  endfunction

  // drive a row, then check the reply stream
  task automatic run_row(input int n, input int off, input bit use_last,
                         input bit noise, input string tag);
    logic [W-1:0] e;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_llr   = W'(vec[k]);
      in_last  = use_last && (k == n - 1);
      offset   = (W-1)'(off);
    end
    @(negedge clk);
    offset = (W-1)'(off ^ 85);
    if (noise) begin in_valid = 1'b1; in_llr = 8'h01; in_last = 1'b1; end
    else       begin in_valid = 1'b0; in_last = 1'b0; end
    for (int j = 0; j < n; j++) begin
      if (j > 0) @(negedge clk);
      e = exp_msg(n, off, j);
      chk(out_valid === 1'b1, {tag, " R6 valid"}, int'(out_valid), 1);
      chk(out_msg === e, tag, int'($signed(out_msg)), int'($signed(e)));
      chk(out_last === (j == n - 1), {tag, " R6 last"}, int'(out_last), int'(j == n - 1));
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(out_valid === 1'b0, {tag, " R6 end"}, int'(out_valid), 0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);
    chk(out_last === 1'b0, "R1 last", int'(out_last), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_signs;
    vec[0] = 0; vec[1] = -3; vec[2] = 7; vec[3] = -9; vec[4] = 12;
    run_row(5, 0, 1'b1, 1'b0, "R2");
  endtask

  task automatic t_saturate;
    vec[0] = -128; vec[1] = 50;
    run_row(2, 0, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_ties;
    vec[0] = -5; vec[1] = 9; vec[2] = 5; vec[3] = 5;
    run_row(4, 1, 1'b1, 1'b0, "R4 tie");
    vec[0] = 40; vec[1] = -2; vec[2] = 33; vec[3] = -60; vec[4] = 3;
    run_row(5, 0, 1'b1, 1'b0, "R4 min2");
  endtask

  task automatic t_offset;
    vec[0] = 20; vec[1] = -30; vec[2] = 40;
    run_row(3, 25, 1'b1, 1'b0, "R5");
    vec[0] = -100; vec[1] = 90; vec[2] = -110;
    run_row(3, 127, 1'b1, 1'b0, "R5 clamp");
  endtask

  task automatic t_single;
    vec[0] = -17;
    run_row(1, 10, 1'b1, 1'b0, "R4 single");
  endtask

  task automatic t_ignore;
    vec[0] = 8; vec[1] = -6; vec[2] = 70;
    run_row(3, 2, 1'b1, 1'b1, "R7");
    vec[0] = 90; vec[1] = 80;
    run_row(2, 0, 1'b1, 1'b0, "R7 next");
  endtask

  task automatic t_autoclose;
    for (int k = 0; k < DMAX; k++) vec[k] = (k % 3 == 0) ? -(k + 20) : (k * 5 + 11);
    run_row(DMAX, 4, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_back2back;
    vec[0] = -1; vec[1] = 2;
    run_row(2, 0, 1'b1, 1'b0, "R9 a");
    vec[0] = 64; vec[1] = 63; vec[2] = -62;
    run_row(3, 0, 1'b1, 1'b0, "R9 b");
  endtask

  initial begin
    t_reset();
    t_signs();
    t_saturate();
    t_ties();
    t_offset();
    t_single();
    t_ignore();
    t_autoclose();
    t_back2back();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule